// File: doc/BRIEF.md
# System-Bus to Peripheral-Bus Bridge

This block joins a single-clock, pipelined system bus to a simple low-bandwidth peripheral bus. On the system side it acts as a slave: it takes each valid transfer, stores its address and direction, and stores the write data from the data phase that follows. On the peripheral side it is the only master. It decodes the stored address into one select line per peripheral and runs a two-step handshake. In the setup step the select is raised with the strobe low. In the access step the strobe is high.

The peripheral bus has no wait-state and no response input, so every peripheral access takes exactly two cycles. The system bus is held with its ready output low until the access step is reached. Read data from the selected peripheral is returned in that access cycle. A read that arrives while an access step finishes goes straight into the next setup step, with no idle cycle between the two.

Top module: `sysbus_periph_bridge`

## Requirements
- R1: During and after synchronous reset the bridge is idle: all `pr_sel` bits low, `pr_stb` low, `sb_ready` high, `sb_rdata` zero.
- R2: A transfer is accepted only at a rising edge where `sb_sel` is high, `sb_trans` is 2'b10 or 2'b11, and `sb_ready_in` is high. With `sb_trans` 2'b00 or 2'b01, or with `sb_sel` low, no select rises and `sb_ready` stays high.
- R3: For an accepted read, the setup cycle is the cycle right after the accepting edge. In it exactly the decoded `pr_sel` bit is high, `pr_stb` is low, `pr_wr` is low and `pr_addr` equals the accepted address.
- R4: For an accepted write, the cycle after acceptance captures `sb_wdata`, with all selects low and `sb_ready` low. The setup cycle follows, with `pr_wr` high and `pr_wdata` holding the captured data through setup and access.
- R5: Setup lasts exactly one cycle and is always followed by the access cycle. In the access cycle `pr_stb` is high and `pr_addr`, `pr_sel` and `pr_wr` keep their setup values.
- R6: The access cycle lasts exactly one cycle. `sb_ready` is low from the accepting edge through the setup cycle, and high in the access cycle, where the system-bus data phase completes.
- R7: In the access cycle of a read, `sb_rdata` equals the selected peripheral's slice of `pr_rdata` (slice i is bits i*DATA_W and up). In every other cycle, and on writes, it is zero.
- R8: Peripheral i (0..3) is selected for addresses from BASE_ADDR + i*0x1000 up to BASE_ADDR + i*0x1000 + 0xFFF, with BASE_ADDR = 0x4000_0000 by default. Any other address selects nothing and reads as zero. Such a transfer still completes with the normal two-cycle timing.
- R9: A read accepted at the edge that ends an access cycle enters setup in the very next cycle. A write accepted there enters its data-capture cycle first.
- R10: `sb_resp` is always 2'b00 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both buses |
| rst | input | 1 | Synchronous active-high reset |
| sb_sel | input | 1 | Slave select from the system-bus decoder |
| sb_trans | input | 2 | Transfer type: 00 idle, 01 busy, 10 first, 11 following |
| sb_write | input | 1 | Direction of the address phase, 1 = write |
| sb_addr | input | ADDR_W | Address-phase address |
| sb_wdata | input | DATA_W | Data-phase write data |
| sb_ready_in | input | 1 | Combined ready seen by all system-bus slaves |
| sb_ready | output | 1 | Ready driven by the bridge, low while stalling |
| sb_rdata | output | DATA_W | Read data returned to the system bus |
| sb_resp | output | 2 | Transfer response, always OKAY |
| pr_addr | output | ADDR_W | Peripheral address |
| pr_sel | output | NUM_PERIPH | One select per peripheral |
| pr_stb | output | 1 | Access strobe, high in the second handshake cycle |
| pr_wr | output | 1 | Peripheral write direction |
| pr_wdata | output | DATA_W | Peripheral write data |
| pr_rdata | input | NUM_PERIPH*DATA_W | Read data of all peripherals, slice i from peripheral i |

## Verification
A fault in the handshake state shows at the peripheral ports in the next cycle: a strobe without a select, a select that persists into idle, or a setup step with no access step after it. A stale capture register shows on `pr_addr`, `pr_wdata` or the decoded select during the same transfer's setup cycle. A wrong stall shows on `sb_ready` one cycle after acceptance. The back-to-back cases show whether the state after an access step is chosen correctly: an extra idle cycle or a missing capture cycle moves every later output by one cycle.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WDATA  = 2'd1,
    ST_SETUP  = 2'd2,
    ST_ENABLE = 2'd3
  } pbr_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/pbr_fsm.sv
module pbr_fsm
  import pbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic       acc_write,
  output pbr_state_e state_q,
  output pbr_state_e state_nx,
  output logic       stb_q,
  output logic       ready_q
);

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE, ST_ENABLE: begin
        if (accept) state_nx = acc_write ? ST_WDATA : ST_SETUP;
        else        state_nx = ST_IDLE;
      end
      ST_WDATA: state_nx = ST_SETUP;
      ST_SETUP: state_nx = ST_ENABLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      stb_q   <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      state_q <= state_nx;
      stb_q   <= (state_nx == ST_ENABLE);
      ready_q <= (state_nx == ST_IDLE) || (state_nx == ST_ENABLE);
    end
  end

  // setup always hands over to access on the next edge
  assert_setup_once_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETUP) |=> (state_q == ST_ENABLE));

  // capture cycle always hands over to setup
  assert_capture_then_setup_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WDATA) |=> (state_q == ST_SETUP));

endmodule

// File: rtl/pbr_decode.sv
module pbr_decode #(
  parameter int          ADDR_W     = 32,
  parameter int          WIN_BITS   = 12,
  parameter int          NUM_PERIPH = 4,
  parameter logic [63:0] BASE_ADDR  = 64'h4000_0000
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_PERIPH-1:0] sel
);

  localparam int PAGE_W = ADDR_W - WIN_BITS;
  localparam logic [PAGE_W-1:0] BASE_PAGE = PAGE_W'(BASE_ADDR >> WIN_BITS);

  logic [PAGE_W-1:0] page;
  assign page = addr[ADDR_W-1:WIN_BITS];

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_win
    localparam logic [PAGE_W-1:0] MY_PAGE = BASE_PAGE + PAGE_W'(g);
    assign sel[g] = (page == MY_PAGE);
  end

endmodule

// File: rtl/pbr_rdmux.sv
module pbr_rdmux #(
  parameter int DATA_W     = 32,
  parameter int NUM_PERIPH = 4
) (
  input  logic [NUM_PERIPH-1:0]        sel,
  input  logic                         gate,
  input  logic [NUM_PERIPH*DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0]            rdata
);

  logic [DATA_W-1:0] masked [NUM_PERIPH];

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_mask
    assign masked[g] = (sel[g] && gate) ? bus_rdata[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PERIPH; i++) rdata = rdata | masked[i];
  end

endmodule

// File: rtl/sysbus_periph_bridge.sv
module sysbus_periph_bridge
  import pbr_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          NUM_PERIPH = 4,
  parameter int          WIN_BITS   = 12,
  parameter logic [63:0] BASE_ADDR  = 64'h4000_0000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sb_sel,
  input  logic [1:0]                   sb_trans,
  input  logic                         sb_write,
  input  logic [ADDR_W-1:0]            sb_addr,
  input  logic [DATA_W-1:0]            sb_wdata,
  input  logic                         sb_ready_in,
  output logic                         sb_ready,
  output logic [DATA_W-1:0]            sb_rdata,
  output logic [1:0]                   sb_resp,
  output logic [ADDR_W-1:0]            pr_addr,
  output logic [NUM_PERIPH-1:0]        pr_sel,
  output logic                         pr_stb,
  output logic                         pr_wr,
  output logic [DATA_W-1:0]            pr_wdata,
  input  logic [NUM_PERIPH*DATA_W-1:0] pr_rdata
);

  pbr_state_e            state_q, state_nx;
  logic                  stb_q, ready_q, accept, rd_gate;
  logic [ADDR_W-1:0]     addr_q, dec_addr;
  logic [DATA_W-1:0]     wdata_q;
  logic                  wr_q;
  logic [NUM_PERIPH-1:0] sel_q, dec_sel;

  // only non-idle, non-busy transfers with the bus ready start an access
  assign accept = sb_sel && sb_trans[1] && sb_ready_in && ready_q;

  pbr_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .acc_write (sb_write),
    .state_q   (state_q),
    .state_nx  (state_nx),
    .stb_q     (stb_q),
    .ready_q   (ready_q)
  );

  assign dec_addr = accept ? sb_addr : addr_q;

  pbr_decode #(
    .ADDR_W     (ADDR_W),
    .WIN_BITS   (WIN_BITS),
    .NUM_PERIPH (NUM_PERIPH),
    .BASE_ADDR  (BASE_ADDR)
  ) u_dec (
    .addr (dec_addr),
    .sel  (dec_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      sel_q   <= '0;
    end else begin
      if (accept) begin
        addr_q <= sb_addr;
        wr_q   <= sb_write;
      end
      if (state_q == ST_WDATA) wdata_q <= sb_wdata;
      if (state_nx == ST_SETUP)       sel_q <= dec_sel;
      else if (state_nx != ST_ENABLE) sel_q <= '0;
    end
  end

  assign rd_gate = (state_q == ST_ENABLE) && !wr_q;

  pbr_rdmux #(
    .DATA_W     (DATA_W),
    .NUM_PERIPH (NUM_PERIPH)
  ) u_rdmux (
    .sel       (sel_q),
    .gate      (rd_gate),
    .bus_rdata (pr_rdata),
    .rdata     (sb_rdata)
  );

  assign sb_ready = ready_q;
  assign sb_resp  = RESP_OKAY;
  assign pr_addr  = addr_q;
  assign pr_sel   = sel_q;
  assign pr_stb   = stb_q;
  assign pr_wr    = wr_q;
  assign pr_wdata = wdata_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (pr_sel == '0 && !pr_stb));

  assert_ignore_nonvalid_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !(sb_sel && sb_trans[1])) |=> (state_q == ST_IDLE));

  assert_access_hold_R5: assert property (@(posedge clk) disable iff (rst)
    pr_stb |-> ($stable(pr_addr) && $stable(pr_sel) && $stable(pr_wr)));

  assert_wdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (pr_stb && pr_wr) |-> $stable(pr_wdata));

  assert_access_once_R6: assert property (@(posedge clk) disable iff (rst)
    pr_stb |=> !pr_stb);

  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETUP || state_q == ST_WDATA) |-> !sb_ready);

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pr_sel));

  assert_b2b_read_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENABLE && sb_sel && sb_trans[1] && !sb_write && sb_ready_in)
      |=> (state_q == ST_SETUP));

endmodule

// File: tb/sysbus_periph_bridge_tb_top.sv
`timescale 1ns/1ps
module sysbus_periph_bridge_tb_top;

  localparam int          AW   = 32;
  localparam int          DW   = 32;
  localparam int          NP   = 4;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sb_sel = 1'b0;
  logic [1:0]    sb_trans = 2'b00;
  logic          sb_write = 1'b0;
  logic [AW-1:0] sb_addr = '0;
  logic [DW-1:0] sb_wdata = '0;
  logic          sb_ready_in;
  logic          sb_ready;
  logic [DW-1:0] sb_rdata;
  logic [1:0]    sb_resp;
  logic [AW-1:0] pr_addr;
  logic [NP-1:0] pr_sel;
  logic          pr_stb, pr_wr;
  logic [DW-1:0] pr_wdata;
  logic [NP*DW-1:0] pr_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  assign sb_ready_in = sb_ready;

  // peripheral model: each slot returns a tag plus the low address bits
  for (genvar g = 0; g < NP; g++) begin : g_per
    assign pr_rdata[g*DW +: DW] = 32'hC000_0000 | (32'(g) << 16) | {20'b0, pr_addr[11:0]};
  end

  sysbus_periph_bridge dut_i (
    .clk(clk), .rst(rst), .sb_sel(sb_sel), .sb_trans(sb_trans), .sb_write(sb_write),
    .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_ready_in(sb_ready_in),
    .sb_ready(sb_ready), .sb_rdata(sb_rdata), .sb_resp(sb_resp),
    .pr_addr(pr_addr), .pr_sel(pr_sel), .pr_stb(pr_stb), .pr_wr(pr_wr),
    .pr_wdata(pr_wdata), .pr_rdata(pr_rdata)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_sel(input logic [AW-1:0] a);
    if (a >= BASE && a < BASE + 32'(NP * 4096)) return NP'(1) << ((a - BASE) >> 12);
    return '0;
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    if (a >= BASE && a < BASE + 32'(NP * 4096))
      return 32'hC000_0000 | (((a - BASE) >> 12) << 16) | {20'b0, a[11:0]};
    return '0;
  endfunction

  task automatic bus_idle();
    sb_sel = 1'b0; sb_trans = 2'b00; sb_write = 1'b0;
  endtask

  // called at a negedge; returns at the negedge inside the access cycle
  task automatic run_read(input logic [AW-1:0] a);
    sb_sel = 1'b1; sb_trans = 2'b10; sb_write = 1'b0; sb_addr = a;
    @(negedge clk);
    bus_idle();
    chk("R3", "setup sel", pr_sel, exp_sel(a));
    chk("R3", "setup stb", pr_stb, 0);
    chk("R3", "setup wr", pr_wr, 0);
    chk("R3", "setup addr", pr_addr, a);
    chk("R6", "setup ready", sb_ready, 0);
    @(negedge clk);
    chk("R5", "access stb", pr_stb, 1);
    chk("R5", "access sel", pr_sel, exp_sel(a));
    chk("R5", "access addr", pr_addr, a);
    chk("R6", "access ready", sb_ready, 1);
    chk("R7", "read data", sb_rdata, exp_rd(a));
    chk("R10", "resp", sb_resp, 0);
  endtask

  task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    sb_sel = 1'b1; sb_trans = 2'b11; sb_write = 1'b1; sb_addr = a;
    @(negedge clk);
    bus_idle();
    sb_wdata = d;
    chk("R4", "capture sel", pr_sel, 0);
    chk("R4", "capture ready", sb_ready, 0);
    chk("R4", "capture stb", pr_stb, 0);
    @(negedge clk);
    sb_wdata = ~d;
    chk("R4", "setup sel", pr_sel, exp_sel(a));
    chk("R4", "setup wr", pr_wr, 1);
    chk("R4", "setup wdata", pr_wdata, d);
    chk("R4", "setup stb", pr_stb, 0);
    @(negedge clk);
    chk("R5", "access stb", pr_stb, 1);
    chk("R4", "access wdata", pr_wdata, d);
    chk("R6", "access ready", sb_ready, 1);
    chk("R7", "write rdata", sb_rdata, 0);
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    chk(req, "idle sel", pr_sel, 0);
    chk(req, "idle stb", pr_stb, 0);
    chk(req, "idle ready", sb_ready, 1);
    chk("R7", "idle rdata", sb_rdata, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset sel", pr_sel, 0);
    chk("R1", "reset stb", pr_stb, 0);
    chk("R1", "reset ready", sb_ready, 1);
    chk("R1", "reset rdata", sb_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset sel", pr_sel, 0);
    chk("R10", "post-reset resp", sb_resp, 0);
  endtask

  task automatic t_reads_each();
    for (int i = 0; i < NP; i++) begin
      run_read(BASE + 32'(i * 4096) + 32'(16 * i + 4));
      expect_idle("R6");
    end
  endtask

  task automatic t_ignore();
    sb_sel = 1'b1; sb_trans = 2'b00; sb_addr = BASE;
    expect_idle("R2");
    sb_trans = 2'b01;
    expect_idle("R2");
    sb_sel = 1'b0; sb_trans = 2'b10;
    expect_idle("R2");
    bus_idle();
    expect_idle("R2");
  endtask

  task automatic t_outside();
    run_read(BASE + 32'h4000);
    expect_idle("R8");
    run_read(32'h0000_0123);
    expect_idle("R8");
    run_write(BASE - 32'h4, 32'h1234_5678);
    expect_idle("R8");
  endtask

  task automatic t_writes();
    run_write(BASE + 32'h3FFC, 32'hDEAD_BEEF);
    expect_idle("R6");
    run_write(BASE + 32'h1010, 32'h0BAD_F00D);
    expect_idle("R6");
  endtask

  task automatic t_back_to_back();
    run_read(BASE + 32'h0100);
    run_read(BASE + 32'h2200);   // R9: setup right after access
    run_write(BASE + 32'h3300, 32'hA5A5_5A5A);  // R9: capture cycle first
    run_read(BASE + 32'h1440);
    expect_idle("R9");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_reads_each();
    t_ignore();
    t_writes();
    t_outside();
    t_back_to_back();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule